// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block takes the W operand of an arithmetic unit and forms two images of it at the same time: one moved one place toward the most significant bit and one moved one place toward bit 0. The bit position that each move leaves empty is filled from a four-way source picked by a single two-bit select. That one select serves both directions, so every select value names one left operation and one right operation together. The unit has no state. It is purely combinational, and the flag register that holds the carry lives outside it.

The eight operations are as follows. Going right, the unit can rotate through the carry, rotate the word on itself, shift in a zero, or copy the sign bit. The sign-copy case is an arithmetic halving of a two's-complement value, and chaining it with rotate-through-carry on the lower bytes extends it to longer numbers. Going left, the unit can rotate through the carry, rotate the word on itself, shift in a zero, or shift in a one.

Each image reaches the shared bus only while its own active-low enable is low. When its enable is high, that output is forced to zero, so the outputs can be OR-combined onto a bus. At most one of the two enables may be low at a time. The bit that falls off each end is always presented on its own pin, so the flag logic can capture it as the new carry. The select lines may be shared with other carry controls, because only one source is read in any given cycle.

Top module: `shrot_unit`

## Requirements
- R1: `right_bus[W-2:0]` equals `w_in[W-1:1]` whenever `right_oe_n` is 0.
- R2: When `right_oe_n` is 0, `right_bus[W-1]` is set by `fill_sel` as follows: 0 selects `carry_in`, 1 selects `w_in[0]`, and 2 selects constant 0.
- R3: `left_bus[W-1:1]` equals `w_in[W-2:0]` whenever `left_oe_n` is 0.
- R4: When `left_oe_n` is 0, `left_bus[0]` is set by `fill_sel` as follows: 0 selects `carry_in`, 1 selects `w_in[W-1]`, 2 selects constant 0, and 3 selects constant 1.
- R5: `right_out_bit` equals `w_in[0]` and `left_out_bit` equals `w_in[W-1]`, whatever the values of the select and the enables.
- R6: While `left_oe_n` is 1, `left_bus` is all zeros, and while `right_oe_n` is 1, `right_bus` is all zeros. At most one enable may be low at a time.
- R7: With `fill_sel` = 3 and `right_oe_n` = 0, `right_bus` read as signed equals the floor of signed `w_in` divided by two.
- R8: `carry_in` has no effect on either bus when `fill_sel` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_in | input | W | Operand to be moved |
| carry_in | input | 1 | Stored carry flag, used as a fill source |
| fill_sel | input | 2 | Fill source select, shared by both directions |
| left_oe_n | input | 1 | Active-low enable for the left image |
| right_oe_n | input | 1 | Active-low enable for the right image |
| left_bus | output | W | Left image, or zero when disabled |
| right_bus | output | W | Right image, or zero when disabled |
| left_out_bit | output | 1 | Bit leaving the word on a left move |
| right_out_bit | output | 1 | Bit leaving the word on a right move |

## Verification
Every 8-bit operand is applied under all four select values, with the carry both clear and set, and under each legal enable pattern. Driving both carry values under the non-carry selects shows that the carry reaches the fill bit only through select 0. The sign-bit case is scored against arithmetic floor division, which makes negative odd values stand apart from a plain logical shift. The disabled-enable patterns confirm that each image is held at zero on its own, independent of the other.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        FILL_CARRY = 2'd0,
        FILL_ROT   = 2'd1,
        FILL_ZERO  = 2'd2,
        FILL_EDGE  = 2'd3
    } fill_src_e;

endpackage

// File: rtl/shrot_fill_sel.sv
module shrot_fill_sel
    import shrot_pkg::*;
(
    input  fill_src_e sel,
    input  logic      carry_bit,
    input  logic      rot_bit,
    input  logic      edge_bit,
    output logic      fill_bit
);

    always_comb begin
        unique case (sel)
            FILL_CARRY: fill_bit = carry_bit;
            FILL_ROT:   fill_bit = rot_bit;
            FILL_ZERO:  fill_bit = 1'b0;
            FILL_EDGE:  fill_bit = edge_bit;
            default:    fill_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W       = 8,
    parameter bit IS_LEFT = 1'b0
) (
    input  logic [W-1:0] w_val,
    input  logic         carry_bit,
    input  fill_src_e    sel,
    output logic [W-1:0] img,
    output logic         out_bit
);

    localparam int MSB = W - 1;

    logic fill_bit;
    logic rot_src;
    logic edge_src;

    generate
        if (IS_LEFT) begin : g_left
            assign rot_src  = w_val[MSB];
            assign edge_src = 1'b1;
            assign img      = {w_val[MSB-1:0], fill_bit};
            assign out_bit  = w_val[MSB];
        end else begin : g_right
            assign rot_src  = w_val[0];
            assign edge_src = w_val[MSB];
            assign img      = {fill_bit, w_val[MSB:1]};
            assign out_bit  = w_val[0];
        end
    endgenerate

    shrot_fill_sel u_fill (
        .sel       (sel),
        .carry_bit (carry_bit),
        .rot_bit   (rot_src),
        .edge_bit  (edge_src),
        .fill_bit  (fill_bit)
    );

endmodule

// File: rtl/shrot_gate.sv
module shrot_gate #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] img,
    output logic [W-1:0] bus
);

    always_comb begin
        bus = oe_n ? '0 : img;
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] w_in,
    input  logic         carry_in,
    input  logic [1:0]   fill_sel,
    input  logic         left_oe_n,
    input  logic         right_oe_n,
    output logic [W-1:0] left_bus,
    output logic [W-1:0] right_bus,
    output logic         left_out_bit,
    output logic         right_out_bit
);

    localparam int LANES = 2;
    localparam int MSB   = W - 1;

    fill_src_e   sel;
    logic [W-1:0] img  [LANES];
    logic [W-1:0] bus  [LANES];
    logic         obit [LANES];
    logic         oe_n [LANES];

    assign sel     = fill_src_e'(fill_sel);
    assign oe_n[0] = right_oe_n;
    assign oe_n[1] = left_oe_n;

    for (genvar d = 0; d < LANES; d++) begin : g_lane
        shrot_lane #(
            .W       (W),
            .IS_LEFT (d == 1)
        ) u_lane (
            .w_val     (w_in),
            .carry_bit (carry_in),
            .sel       (sel),
            .img       (img[d]),
            .out_bit   (obit[d])
        );

        shrot_gate #(
            .W (W)
        ) u_gate (
            .oe_n (oe_n[d]),
            .img  (img[d]),
            .bus  (bus[d])
        );
    end

    assign right_bus     = bus[0];
    assign left_bus      = bus[1];
    assign right_out_bit = obit[0];
    assign left_out_bit  = obit[1];

    always_comb begin
        AST_RIGHT_BODY: assert (img[0][MSB-1:0] == w_in[MSB:1])
            else $error("right image body mismatch"); // R1
        AST_LEFT_BODY: assert (img[1][MSB:1] == w_in[MSB-1:0])
            else $error("left image body mismatch"); // R3
        AST_ROT_KEEPS_ONES: assert (sel != FILL_ROT || $countones(img[1]) == $countones(w_in))
            else $error("left rotate changed the ones count"); // R4
        AST_RIGHT_ROT_KEEPS_ONES: assert (sel != FILL_ROT || $countones(img[0]) == $countones(w_in))
            else $error("right rotate changed the ones count"); // R2
        AST_ONE_ENABLE: assert (left_oe_n || right_oe_n)
            else $error("both bus enables active"); // R6
        AST_LEFT_QUIET: assert (!left_oe_n || left_bus == '0)
            else $error("left bus driven while disabled"); // R6
        AST_RIGHT_QUIET: assert (!right_oe_n || right_bus == '0)
            else $error("right bus driven while disabled"); // R6
        AST_SIGN_KEPT: assert (sel != FILL_EDGE || img[0][MSB] == w_in[MSB])
            else $error("arithmetic right lost the sign"); // R7
    end

endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;

    localparam int  W        = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  WDOG_MAX = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] w_in = '0;
    logic         carry_in = 1'b0;
    logic [1:0]   fill_sel = 2'd0;
    logic         left_oe_n = 1'b1;
    logic         right_oe_n = 1'b1;
    logic [W-1:0] left_bus;
    logic [W-1:0] right_bus;
    logic         left_out_bit;
    logic         right_out_bit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    shrot_unit #(.W(W)) dut_i (
        .w_in          (w_in),
        .carry_in      (carry_in),
        .fill_sel      (fill_sel),
        .left_oe_n     (left_oe_n),
        .right_oe_n    (right_oe_n),
        .left_bus      (left_bus),
        .right_bus     (right_bus),
        .left_out_bit  (left_out_bit),
        .right_out_bit (right_out_bit)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s w=%0d sel=%0d c=%0d actual=%0d expected=%0d",
                     tag, w_in, fill_sel, carry_in, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_MAX && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WDOG_MAX);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle left", int'(left_bus), 0);
        check("R6 idle right", int'(right_bus), 0);

        for (int en = 0; en < 3; en++) begin
            for (int s = 0; s < 4; s++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int w = 0; w < 256; w++) begin
                        int rfill;
                        int lfill;
                        int rexp;
                        int lexp;
                        int sw;
                        @(posedge clk);
                        w_in       = W'(w);
                        fill_sel   = 2'(s);
                        carry_in   = 1'(c);
                        left_oe_n  = (en != 1);
                        right_oe_n = (en != 2);
                        @(negedge clk);
                        case (s)
                            0: begin rfill = c;          lfill = c;          end
                            1: begin rfill = w % 2;      lfill = w / 128;    end
                            2: begin rfill = 0;          lfill = 0;          end
                            default: begin rfill = w / 128; lfill = 1;       end
                        endcase
                        rexp = w / 2 + rfill * 128;
                        lexp = (w * 2) % 256 + lfill;
                        check("R5 right out", int'(right_out_bit), w % 2);
                        check("R5 left out", int'(left_out_bit), w / 128);
                        if (en == 2) begin
                            check("R1 right body", int'(right_bus) % 128, w / 2);
                            if (s == 3) begin
                                sw = (w >= 128) ? w - 256 : w;
                                check("R7 signed half", int'($signed(right_bus)),
                                      (sw - ((sw % 2 != 0) ? 1 : 0)) / 2);
                            end else if (s != 0 && c == 1) begin
                                check("R8 right carry ignored", int'(right_bus), rexp);
                            end else begin
                                check("R2 right fill", int'(right_bus) / 128, rfill);
                            end
                            check("R6 left quiet", int'(left_bus), 0);
                        end else if (en == 1) begin
                            check("R3 left body", int'(left_bus) / 2, (w * 2 % 256) / 2);
                            if (s != 0 && c == 1)
                                check("R8 left carry ignored", int'(left_bus), lexp);
                            else
                                check("R4 left fill", int'(left_bus) % 2, lfill);
                            check("R6 right quiet", int'(right_bus), 0);
                        end else begin
                            check("R6 both off left", int'(left_bus), 0);
                            check("R6 both off right", int'(right_bus), 0);
                        end
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule